// File: doc/BRIEF.md
# Depth-First Subpatch Search Controller

This block steers a depth-first search over the quadrant subdivisions of a surface patch. It never stores control points. Each stack entry is a path: the fixed-point (u,v) corner of a subpatch on the parent patch, plus the number of halvings that lead to it. The search begins from a single root entry. Each popped entry becomes the current subpatch. The geometry stage then returns four quadrant verdicts for it: hit, terminated and entry distance t_in. Quadrants that are hit but not terminated become child paths and go back on the stack. Quadrants that are hit and terminated become results that carry (u, v, t).

There are two search modes. In all-results mode, every terminated hit is reported, and children are stacked so that the lowest quadrant index is explored first. In nearest mode, the surviving children are ranked by t_in so that the nearest is popped first. Only a terminated hit that is strictly closer than the best one so far is reported, and children that cannot beat that best result are discarded. A pop on an empty stack ends the search.

Top module: `dfs_search_ctrl`

## Requirements
- R1: A `start` pulse leaves exactly one entry on the stack, the root (u=0, v=0, depth 0), and clears `done` and `overflow`. The first pop then returns that root.
- R2: Quadrant index k adds bit k[0] to u and bit k[1] to v. The bit is placed at position UW-1-d, where d is the parent depth (the MSB weighs one half), and the child depth is d+1. For example, quadrant 3 of the root gives u=v=0x80 at depth 1.
- R3: A verdict whose pushes would raise the occupancy above 3*DMAX+1 writes nothing and sets `overflow`. The flag stays set until the next `start`.
- R4: In all-results mode, the children of one verdict are popped in ascending quadrant index.
- R5: In nearest mode, the children of one verdict are popped in ascending t_in, and equal t_in values are popped lower index first.
- R6: In all-results mode, each hit-and-terminated quadrant k raises `res_valid[k]` in the cycle after the verdict. Its lane carries the child (u,v) and t = t_in.
- R7: In nearest mode, at most one lane is reported per verdict. It is the smallest-t_in terminated hit (lower index on ties), and it is reported only if its t_in is strictly below every result already reported since `start`.
- R8: In nearest mode, a hit, non-terminated quadrant is pushed only if its t_in is strictly below the best result, counting a result from the same verdict.
- R9: A child that would reach depth DMAX counts as terminated, whatever its terminated flag says. No popped entry has a depth of DMAX or more.
- R10: A pop on an empty stack gives `ent_valid`=0 and sets `done` in the next cycle. `done` stays set until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search from the root |
| near_mode | input | 1 | 1 = nearest mode, 0 = all-results mode; held for the whole search |
| pop_req | input | 1 | Request the next entry to test |
| qv_valid | input | 1 | Quadrant verdicts for the current entry are present |
| q_hit | input | 4 | Ray hits quadrant k |
| q_term | input | 4 | Quadrant k meets the accuracy limit |
| q_tin | input | 4*TW | Entry distance per quadrant, lane k at bits [k*TW +: TW] |
| ent_valid | output | 1 | A popped entry is presented |
| ent_u | output | UW | u corner of the current entry |
| ent_v | output | UW | v corner of the current entry |
| ent_d | output | DW | Depth of the current entry |
| done | output | 1 | Search finished, stack empty |
| overflow | output | 1 | A push did not fit |
| res_valid | output | 4 | Result present on lane k |
| res_u | output | 4*UW | Result u per lane |
| res_v | output | 4*UW | Result v per lane |
| res_t | output | 4*TW | Result t per lane |

## Verification
The assertions assume three things about the inputs. `start`, `pop_req` and `qv_valid` are never raised in the same cycle. `near_mode` does not change between a `start` and the matching `done`. A verdict refers to the entry most recently popped, or to the root after `start`. The bench keeps within these rules because each of its tasks raises exactly one strobe for one cycle and changes the mode only when it issues `start`. The only deliberate misuse is a string of verdicts sent with no pops between them, which drives the stack into overflow.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
   localparam int NQ  = 4;
   localparam int RKW = 2;
   typedef enum logic {SRCH_ALL = 1'b0, SRCH_NEAR = 1'b1} srch_mode_e;
endpackage

// File: rtl/dfs_rank4.sv
module dfs_rank4
   import dfs_pkg::*;
#(
   parameter int KW = 12
) (
   input  logic [KW-1:0]  key   [NQ],
   input  logic [NQ-1:0]  sel,
   output logic [RKW-1:0] rank  [NQ],
   output logic [RKW:0]   count
);
   // rank = number of selected lanes that must sit deeper (popped later)
   always_comb begin
      for (int i = 0; i < NQ; i++) begin
         rank[i] = '0;
         for (int j = 0; j < NQ; j++) begin
            if (j != i && sel[j] &&
                (key[j] > key[i] || (key[j] == key[i] && j > i)))
               rank[i] = rank[i] + RKW'(1);
         end
      end
   end

   always_comb begin
      count = '0;
      for (int j = 0; j < NQ; j++)
         count = count + {{RKW{1'b0}}, sel[j]};
   end
endmodule

// File: rtl/dfs_path_stack.sv
module dfs_path_stack
   import dfs_pkg::*;
#(
   parameter int UW     = 8,
   parameter int DW     = 4,
   parameter int SDEPTH = 25,
   parameter int SPW    = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           push_en,
   input  logic           pop,
   input  logic [NQ-1:0]  wr_mask,
   input  logic [RKW-1:0] wr_slot [NQ],
   input  logic [RKW:0]   n_push,
   input  logic [UW-1:0]  wr_u    [NQ],
   input  logic [UW-1:0]  wr_v    [NQ],
   input  logic [DW-1:0]  wr_d    [NQ],
   output logic [UW-1:0]  top_u,
   output logic [UW-1:0]  top_v,
   output logic [DW-1:0]  top_d,
   output logic           empty,
   output logic           ovf
);
   localparam logic [SPW:0] CAP = SDEPTH[SPW:0];

   if (SPW <= RKW) begin : g_chk_spw
      $error("dfs_path_stack: SPW too narrow");
   end

   logic [SPW-1:0] sp;
   logic [SPW:0]   sum_sp;
   logic           fits;
   logic [SPW-1:0] wr_idx [NQ];
   logic [SPW-1:0] rd_idx;
   logic [UW-1:0]  mem_u [SDEPTH];
   logic [UW-1:0]  mem_v [SDEPTH];
   logic [DW-1:0]  mem_d [SDEPTH];

   assign sum_sp = {1'b0, sp} + {{(SPW-RKW){1'b0}}, n_push};
   assign fits   = (sum_sp <= CAP);
   assign empty  = (sp == '0);
   assign rd_idx = sp - SPW'(1);
   assign top_u  = mem_u[rd_idx];
   assign top_v  = mem_v[rd_idx];
   assign top_d  = mem_d[rd_idx];

   for (genvar k = 0; k < NQ; k++) begin : g_idx
      assign wr_idx[k] = sp + {{(SPW-RKW){1'b0}}, wr_slot[k]};
   end

   always_ff @(posedge clk) begin
      if (start) begin
         mem_u[0] <= '0;
         mem_v[0] <= '0;
         mem_d[0] <= '0;
      end else if (push_en && fits) begin
         for (int k = 0; k < NQ; k++) begin
            if (wr_mask[k]) begin
               mem_u[wr_idx[k]] <= wr_u[k];
               mem_v[wr_idx[k]] <= wr_v[k];
               mem_d[wr_idx[k]] <= wr_d[k];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp  <= '0;
         ovf <= 1'b0;
      end else if (start) begin
         sp  <= SPW'(1);
         ovf <= 1'b0;
      end else if (push_en) begin
         if (fits) sp  <= sum_sp[SPW-1:0];
         else      ovf <= 1'b1;
      end else if (pop && !empty) begin
         sp <= sp - SPW'(1);
      end
   end

   assert_start_root_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (sp == SPW'(1)));
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && !start && !fits) |=> (ovf && sp == $past(sp)));
   assert_sp_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, sp} <= CAP));
endmodule

// File: rtl/dfs_result_sel.sv
module dfs_result_sel
   import dfs_pkg::*;
#(
   parameter int TW    = 12,
   parameter bit PRUNE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          qv_valid,
   input  logic          near,
   input  logic [NQ-1:0] cand,
   input  logic [NQ-1:0] grow,
   input  logic [TW-1:0] tin [NQ],
   output logic [NQ-1:0] res_sel,
   output logic [NQ-1:0] keep
);
   srch_mode_e     mode;
   logic           best_vld, nb_vld, min_found, beats;
   logic [TW-1:0]  best_t, nb_t, min_t;
   logic [RKW-1:0] min_idx;

   assign mode = near ? SRCH_NEAR : SRCH_ALL;

   always_comb begin
      min_found = 1'b0;
      min_idx   = '0;
      min_t     = '0;
      for (int k = 0; k < NQ; k++) begin
         if (cand[k] && (!min_found || tin[k] < min_t)) begin
            min_found = 1'b1;
            min_idx   = RKW'(k);
            min_t     = tin[k];
         end
      end
      beats  = min_found && (!best_vld || min_t < best_t);
      nb_vld = best_vld || beats;
      nb_t   = beats ? min_t : best_t;
      if (mode == SRCH_NEAR) res_sel = beats ? (NQ'(1) << min_idx) : '0;
      else                   res_sel = cand;
   end

   if (PRUNE) begin : g_prune
      for (genvar k = 0; k < NQ; k++) begin : g_keep
         assign keep[k] = grow[k] &&
                          (mode == SRCH_ALL || !nb_vld || tin[k] < nb_t);
      end
   end else begin : g_noprune
      assign keep = grow;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_vld <= 1'b0;
         best_t   <= '0;
      end else if (start) begin
         best_vld <= 1'b0;
      end else if (qv_valid && mode == SRCH_NEAR && beats) begin
         best_vld <= 1'b1;
         best_t   <= min_t;
      end
   end

   assert_best_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (best_vld && $past(best_vld) && !$past(start)) |-> (best_t <= $past(best_t)));
endmodule

// File: rtl/dfs_search_ctrl.sv
module dfs_search_ctrl
   import dfs_pkg::*;
#(
   parameter int DMAX  = 8,
   parameter int TW    = 12,
   parameter bit PRUNE = 1'b1,
   localparam int UW     = DMAX,
   localparam int DW     = $clog2(DMAX + 1),
   localparam int SDEPTH = 3 * DMAX + 1,
   localparam int SPW    = $clog2(SDEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             near_mode,
   input  logic             pop_req,
   input  logic             qv_valid,
   input  logic [3:0]       q_hit,
   input  logic [3:0]       q_term,
   input  logic [4*TW-1:0]  q_tin,
   output logic             ent_valid,
   output logic [UW-1:0]    ent_u,
   output logic [UW-1:0]    ent_v,
   output logic [DW-1:0]    ent_d,
   output logic             done,
   output logic             overflow,
   output logic [3:0]       res_valid,
   output logic [4*UW-1:0]  res_u,
   output logic [4*UW-1:0]  res_v,
   output logic [4*TW-1:0]  res_t
);
   if (DMAX < 2) begin : g_chk_dmax
      $error("dfs_search_ctrl: DMAX must be at least 2");
   end
   if (TW < 2) begin : g_chk_tw
      $error("dfs_search_ctrl: TW must be at least 2");
   end

   localparam logic [UW-1:0] HALF = {1'b1, {(UW-1){1'b0}}};

   logic [UW-1:0]  cur_u, cur_v;
   logic [DW-1:0]  cur_d, nxt_d;
   logic [UW-1:0]  pos;
   logic           at_max;
   logic [TW-1:0]  tin  [NQ];
   logic [TW-1:0]  key  [NQ];
   logic [UW-1:0]  ch_u [NQ];
   logic [UW-1:0]  ch_v [NQ];
   logic [DW-1:0]  ch_d [NQ];
   logic [NQ-1:0]  term_v, cand, grow, keep, res_sel;
   logic [RKW-1:0] rank [NQ];
   logic [RKW:0]   n_keep;
   logic [UW-1:0]  top_u, top_v;
   logic [DW-1:0]  top_d;
   logic           empty, push_en, pop_en;

   assign pos    = HALF >> cur_d;
   assign nxt_d  = cur_d + DW'(1);
   assign at_max = (nxt_d == DW'(DMAX));
   assign term_v = q_term | {NQ{at_max}};
   assign cand   = q_hit & term_v;
   assign grow   = q_hit & ~term_v;
   assign push_en = qv_valid && !start;
   assign pop_en  = pop_req && !qv_valid && !start;

   for (genvar k = 0; k < NQ; k++) begin : g_lane
      assign tin[k]  = q_tin[k*TW +: TW];
      assign key[k]  = near_mode ? tin[k] : '0;
      assign ch_u[k] = ((k % 2) == 1) ? (cur_u | pos) : cur_u;
      assign ch_v[k] = ((k / 2) == 1) ? (cur_v | pos) : cur_v;
      assign ch_d[k] = nxt_d;
   end

   dfs_result_sel #(.TW(TW), .PRUNE(PRUNE)) u_sel (
      .clk(clk), .rst_n(rst_n), .start(start), .qv_valid(qv_valid),
      .near(near_mode), .cand(cand), .grow(grow), .tin(tin),
      .res_sel(res_sel), .keep(keep)
   );

   dfs_rank4 #(.KW(TW)) u_rank (
      .key(key), .sel(keep), .rank(rank), .count(n_keep)
   );

   dfs_path_stack #(.UW(UW), .DW(DW), .SDEPTH(SDEPTH), .SPW(SPW)) u_stack (
      .clk(clk), .rst_n(rst_n), .start(start), .push_en(push_en), .pop(pop_en),
      .wr_mask(keep), .wr_slot(rank), .n_push(n_keep),
      .wr_u(ch_u), .wr_v(ch_v), .wr_d(ch_d),
      .top_u(top_u), .top_v(top_v), .top_d(top_d),
      .empty(empty), .ovf(overflow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_u     <= '0;
         cur_v     <= '0;
         cur_d     <= '0;
         ent_valid <= 1'b0;
         done      <= 1'b0;
         res_valid <= '0;
         res_u     <= '0;
         res_v     <= '0;
         res_t     <= '0;
      end else begin
         ent_valid <= 1'b0;
         res_valid <= '0;
         if (start) begin
            cur_u <= '0;
            cur_v <= '0;
            cur_d <= '0;
            done  <= 1'b0;
         end else if (qv_valid) begin
            res_valid <= res_sel;
            for (int k = 0; k < NQ; k++) begin
               res_u[k*UW +: UW] <= ch_u[k];
               res_v[k*UW +: UW] <= ch_v[k];
               res_t[k*TW +: TW] <= tin[k];
            end
         end else if (pop_req) begin
            if (empty) begin
               done <= 1'b1;
            end else begin
               ent_valid <= 1'b1;
               cur_u     <= top_u;
               cur_v     <= top_v;
               cur_d     <= top_d;
            end
         end
      end
   end

   assign ent_u = cur_u;
   assign ent_v = cur_v;
   assign ent_d = cur_d;

   assert_done_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);
   assert_ent_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid |-> (ent_d < DW'(DMAX)));
   assert_near_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(near_mode) && $past(qv_valid)) |-> $onehot0(res_valid));
   assert_done_no_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(done)) |-> !ent_valid);
endmodule

// File: tb/tb_dfs_search_ctrl.sv
`timescale 1ns/1ps
module tb_dfs_search_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, near_mode = 1'b0, pop_req = 1'b0, qv_valid = 1'b0;
   logic [3:0]  q_hit = '0, q_term = '0;
   logic [47:0] q_tin = '0;
   logic        ent_valid, done, overflow;
   logic [7:0]  ent_u, ent_v;
   logic [3:0]  ent_d;
   logic [3:0]  res_valid;
   logic [31:0] res_u, res_v;
   logic [47:0] res_t;
   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   dfs_search_ctrl dut (
      .clk(clk), .rst_n(rst_n), .start(start), .near_mode(near_mode),
      .pop_req(pop_req), .qv_valid(qv_valid), .q_hit(q_hit), .q_term(q_term),
      .q_tin(q_tin), .ent_valid(ent_valid), .ent_u(ent_u), .ent_v(ent_v),
      .ent_d(ent_d), .done(done), .overflow(overflow), .res_valid(res_valid),
      .res_u(res_u), .res_v(res_v), .res_t(res_t)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic do_start(input logic nm);
      near_mode = nm;
      start = 1'b1;
      tick();
      start = 1'b0;
   endtask

   task automatic pop_expect(input string tag, input logic [7:0] eu, input logic [7:0] ev,
                             input logic [3:0] ed);
      pop_req = 1'b1;
      tick();
      pop_req = 1'b0;
      chk({tag, " valid"}, ent_valid, 1);
      chk({tag, " u"}, ent_u, eu);
      chk({tag, " v"}, ent_v, ev);
      chk({tag, " depth"}, ent_d, ed);
   endtask

   task automatic pop_empty(input string tag);
      pop_req = 1'b1;
      tick();
      pop_req = 1'b0;
      chk({tag, " no entry"}, ent_valid, 0);
      chk({tag, " done"}, done, 1);
   endtask

   task automatic quad(input logic [3:0] h, input logic [3:0] t, input logic [11:0] t0,
                       input logic [11:0] t1, input logic [11:0] t2, input logic [11:0] t3);
      q_hit = h;
      q_term = t;
      q_tin = {t3, t2, t1, t0};
      qv_valid = 1'b1;
      tick();
      qv_valid = 1'b0;
   endtask

   task automatic test_reset;
      chk("R1 reset done", done, 0);
      chk("R3 reset overflow", overflow, 0);
      chk("R1 reset ent_valid", ent_valid, 0);
      chk("R6 reset res_valid", res_valid, 0);
   endtask

   task automatic test_root_R1;
      do_start(1'b0);
      chk("R1 done cleared", done, 0);
      pop_expect("R1 root", 8'h00, 8'h00, 4'd0);
      pop_empty("R10 after root");
      tick();
      chk("R10 done holds", done, 1);
   endtask

   task automatic test_all_order_R4;
      do_start(1'b0);
      pop_expect("R1 root", 8'h00, 8'h00, 4'd0);
      quad(4'b1111, 4'b0000, 12'd5, 12'd6, 12'd7, 12'd8);
      chk("R4 no result", res_valid, 0);
      pop_expect("R4 q0 first", 8'h00, 8'h00, 4'd1);
      quad(4'b1000, 4'b0000, 12'd1, 12'd1, 12'd1, 12'd1);
      pop_expect("R2 depth2 child", 8'h40, 8'h40, 4'd2);
      pop_expect("R4 q1 second", 8'h80, 8'h00, 4'd1);
      pop_expect("R4 q2 third", 8'h00, 8'h80, 4'd1);
      pop_expect("R2 R4 q3 last", 8'h80, 8'h80, 4'd1);
      pop_empty("R10 all order");
   endtask

   task automatic test_all_results_R6;
      do_start(1'b0);
      pop_expect("R1 root", 8'h00, 8'h00, 4'd0);
      quad(4'b1111, 4'b0101, 12'd11, 12'd22, 12'd33, 12'd44);
      chk("R6 lanes", res_valid, 4'b0101);
      chk("R6 lane0 u", res_u[7:0], 8'h00);
      chk("R6 lane0 t", res_t[11:0], 12'd11);
      chk("R6 lane2 v", res_v[23:16], 8'h80);
      chk("R6 lane2 u", res_u[23:16], 8'h00);
      chk("R6 lane2 t", res_t[35:24], 12'd33);
      tick();
      chk("R6 pulse only", res_valid, 0);
      pop_expect("R4 q1 pushed", 8'h80, 8'h00, 4'd1);
      pop_expect("R4 q3 pushed", 8'h80, 8'h80, 4'd1);
      pop_empty("R10 all results");
   endtask

   task automatic test_near_sort_R5;
      do_start(1'b1);
      pop_expect("R1 root", 8'h00, 8'h00, 4'd0);
      quad(4'b1111, 4'b0000, 12'd50, 12'd20, 12'd50, 12'd10);
      pop_expect("R5 t10 q3", 8'h80, 8'h80, 4'd1);
      pop_expect("R5 t20 q1", 8'h80, 8'h00, 4'd1);
      pop_expect("R5 tie q0", 8'h00, 8'h00, 4'd1);
      pop_expect("R5 tie q2", 8'h00, 8'h80, 4'd1);
      pop_empty("R10 near sort");
   endtask

   task automatic test_near_results_R7_R8;
      do_start(1'b1);
      pop_expect("R1 root", 8'h00, 8'h00, 4'd0);
      quad(4'b1111, 4'b1110, 12'd40, 12'd30, 12'd25, 12'd25);
      chk("R7 single tie lane", res_valid, 4'b0100);
      chk("R7 lane2 t", res_t[35:24], 12'd25);
      chk("R7 lane2 v", res_v[23:16], 8'h80);
      pop_empty("R8 far child pruned");

      do_start(1'b1);
      pop_expect("R1 root", 8'h00, 8'h00, 4'd0);
      quad(4'b1111, 4'b0001, 12'd30, 12'd20, 12'd30, 12'd40);
      chk("R7 first result", res_valid, 4'b0001);
      chk("R7 first t", res_t[11:0], 12'd30);
      pop_expect("R8 only nearer kept", 8'h80, 8'h00, 4'd1);
      quad(4'b0001, 4'b0001, 12'd35, 12'd0, 12'd0, 12'd0);
      chk("R7 farther ignored", res_valid, 4'b0000);
      quad(4'b0010, 4'b0010, 12'd0, 12'd10, 12'd0, 12'd0);
      chk("R7 closer reported", res_valid, 4'b0010);
      chk("R7 closer u", res_u[15:8], 8'hC0);
      chk("R7 closer t", res_t[23:12], 12'd10);
      pop_empty("R8 stack drained");
   endtask

   task automatic test_depth_limit_R9;
      do_start(1'b0);
      pop_expect("R1 root", 8'h00, 8'h00, 4'd0);
      for (int d = 1; d < 8; d++) begin
         quad(4'b0001, 4'b0000, 12'd1, 12'd1, 12'd1, 12'd1);
         chk("R9 no early result", res_valid, 0);
         pop_expect("R9 descend", 8'h00, 8'h00, 4'(d));
      end
      quad(4'b1000, 4'b0000, 12'd0, 12'd0, 12'd0, 12'd77);
      chk("R9 forced result", res_valid, 4'b1000);
      chk("R9 R2 lsb u", res_u[31:24], 8'h01);
      chk("R9 R2 lsb v", res_v[31:24], 8'h01);
      chk("R9 t", res_t[47:36], 12'd77);
      pop_empty("R9 nothing pushed");
   endtask

   task automatic test_overflow_R3;
      int got;
      do_start(1'b0);
      for (int i = 0; i < 6; i++)
         quad(4'b1111, 4'b0000, 12'd1, 12'd2, 12'd3, 12'd4);
      chk("R3 full no flag", overflow, 0);
      quad(4'b1111, 4'b0000, 12'd1, 12'd2, 12'd3, 12'd4);
      chk("R3 flag set", overflow, 1);
      got = 0;
      for (int i = 0; i < 26; i++) begin
         pop_req = 1'b1;
         tick();
         pop_req = 1'b0;
         if (ent_valid) got++;
      end
      chk("R3 nothing written", got, 25);
      chk("R3 flag sticky", overflow, 1);
      chk("R10 done after drain", done, 1);
      do_start(1'b0);
      chk("R3 start clears", overflow, 0);
   endtask

   initial begin
      #(4 * 100000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      test_reset();
      test_root_R1();
      test_all_order_R4();
      test_all_results_R6();
      test_near_sort_R5();
      test_near_results_R7_R8();
      test_depth_limit_R9();
      test_overflow_R3();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule